// File: doc/BRIEF.md
# Fault Retry and Soft-Start Sequencer

This block is the digital supervisor of a switching regulator's output stage. It decides when the power stage may switch, when a soft-start ramp must be requested, when peak-current limiting is in force, and when a fault must be shown to the power-good logic. Its inputs are flags from comparators that already exist around it: enable, peak current limit, short circuit, over-temperature, temperature recovered (hysteresis already applied) and soft-start complete. It also takes a slow timebase tick. All delays are counted in ticks.

The controller is a six-state machine:

- `ST_STANDBY`: output off.
- `ST_SOFTSTART`: output on, ramp requested.
- `ST_RUN`: normal regulation.
- `ST_LIMIT`: cycle-by-cycle limiting with a grace timer.
- `ST_COOLDOWN`: thermal shutdown, waiting for the temperature to recover.
- `ST_RETRY`: output off, timing a fixed delay before a fresh soft start.

The named transitions are:

- wake: `ST_STANDBY` to `ST_SOFTSTART`
- ramp-done: `ST_SOFTSTART` to `ST_RUN`
- overload: `ST_SOFTSTART` or `ST_RUN` to `ST_LIMIT`
- recover: `ST_LIMIT` to `ST_RUN`
- grace-expired: `ST_LIMIT` to `ST_RETRY`
- short: any active state to `ST_RETRY`
- overheat: any active state to `ST_COOLDOWN`
- cooled: `ST_COOLDOWN` to `ST_RETRY`
- restart: `ST_RETRY` to `ST_SOFTSTART`
- sleep: any state to `ST_STANDBY`

The active states are `ST_SOFTSTART`, `ST_RUN` and `ST_LIMIT`.

Each output is decoded from the state register. In the requirements below, outputs are written as {out_en_o, ss_req_o, cbc_limit_o, fault_o}:

- off = 0000
- ramp = 1100
- run = 1000
- limit = 1010
- fault = 0001

Top module: `psu_retry_seq`

## Requirements
- R1: While rst_n is low, and after its release with en_i low, the machine is in `ST_STANDBY` and the outputs read off (0000).
- R2: In `ST_STANDBY` with en_i high, the next clock enters `ST_SOFTSTART` (outputs 1100). Every exit from standby, reset or a fault passes through this state.
- R3: In `ST_SOFTSTART` with ss_done_i high and no fault flag, the next clock enters `ST_RUN` (outputs 1000). While ss_done_i stays low, the state holds.
- R4: ilim_i high in `ST_SOFTSTART` or `ST_RUN` enters `ST_LIMIT` on the next clock (outputs 1010, output still enabled).
- R5: In `ST_LIMIT`, if ilim_i drops before the grace timer expires, the next clock enters `ST_RUN`. The grace timer restarts from zero on every entry to `ST_LIMIT`.
- R6: When ilim_i stays high in `ST_LIMIT` for LIMIT_TICKS tick pulses, the clock after the last counted tick enters `ST_RETRY` (outputs 0001).
- R7: In `ST_RETRY`, RETRY_TICKS tick pulses are counted. The clock after the last one enters `ST_SOFTSTART`. ilim_i and short_i have no effect in this state.
- R8: short_i high in any active state enters `ST_RETRY` on the next clock, with no grace period.
- R9: otemp_i high in any active state, including `ST_LIMIT`, enters `ST_COOLDOWN` on the next clock (outputs 0001).
- R10: `ST_COOLDOWN` ignores ticks and holds until temp_ok_i is high. It then enters `ST_RETRY` with a retry count of zero.
- R11: When flags arrive together, the priority is otemp_i, then short_i, then ilim_i, then ss_done_i.
- R12: en_i low moves the machine to `ST_STANDBY` on the next clock from any state, and both timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable request |
| ilim_i | input | 1 | Peak current limit reached |
| short_i | input | 1 | Short-circuit current reached |
| otemp_i | input | 1 | Over-temperature detected |
| temp_ok_i | input | 1 | Temperature back below the hysteresis point |
| ss_done_i | input | 1 | Soft-start ramp complete |
| tick_i | input | 1 | Timebase pulse, one clock wide |
| out_en_o | output | 1 | Power stage enable |
| ss_req_o | output | 1 | Soft-start ramp request |
| cbc_limit_o | output | 1 | Cycle-by-cycle current limiting active |
| fault_o | output | 1 | Fault indication to the power-good logic |

## Verification
Every output is decoded from the state register, so any reaction to a flag appears one clock edge after the flag is sampled. The timer paths are the exception: an expiry needs the edge that counts the last tick and then a second edge to take the transition. The driver applies each stimulus at a falling edge and queues the expected output word. The monitor compares that word 1 ns after the next rising edge, so every check lands in the single cycle where the result is due. Timer checks queue "still waiting" words for the counted ticks and then the new state word for the following clock. This catches both an early and a late expiry.

// File: rtl/psu_retry_pkg.sv
package psu_retry_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY   = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_LIMIT     = 3'd3,
        ST_COOLDOWN  = 3'd4,
        ST_RETRY     = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_ILIM  = 2'd1,
        EV_SHORT = 2'd2,
        EV_OTEMP = 2'd3
    } seq_event_t;

endpackage

// File: rtl/seq_fault_prio.sv
module seq_fault_prio
    import psu_retry_pkg::*;
(
    input  logic       otemp_i,
    input  logic       short_i,
    input  logic       ilim_i,
    output seq_event_t event_o
);

    // Thermal beats short circuit, which beats current limit (R11).
    always_comb begin
        if (otemp_i)      event_o = EV_OTEMP;
        else if (short_i) event_o = EV_SHORT;
        else if (ilim_i)  event_o = EV_ILIM;
        else              event_o = EV_NONE;
    end

endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
    parameter int unsigned LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN);

    logic [CW-1:0] cnt_q;

    // Cleared whenever the owning state is not active; saturates at LEN.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

    p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_cnt_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/psu_retry_seq.sv
module psu_retry_seq
    import psu_retry_pkg::*;
#(
    parameter int unsigned LIMIT_TICKS = 10,
    parameter int unsigned RETRY_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ilim_i,
    input  logic short_i,
    input  logic otemp_i,
    input  logic temp_ok_i,
    input  logic ss_done_i,
    input  logic tick_i,
    output logic out_en_o,
    output logic ss_req_o,
    output logic cbc_limit_o,
    output logic fault_o
);

    localparam int unsigned NTIMERS = 2;
    localparam int unsigned TI_LIM = 0;
    localparam int unsigned TI_RET = 1;

    seq_state_t state_q, state_d;
    seq_event_t evt;
    logic [NTIMERS-1:0] t_run, t_done;

    seq_fault_prio u_prio (
        .otemp_i (otemp_i),
        .short_i (short_i),
        .ilim_i  (ilim_i),
        .event_o (evt)
    );

    assign t_run[TI_LIM] = (state_q == ST_LIMIT);
    assign t_run[TI_RET] = (state_q == ST_RETRY);

    genvar gi;
    generate
        for (gi = 0; gi < NTIMERS; gi++) begin : g_tmr
            localparam int unsigned TLEN = (gi == TI_LIM) ? LIMIT_TICKS : RETRY_TICKS;
            seq_tick_timer #(.LEN(TLEN)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .run_i  (t_run[gi]),
                .tick_i (tick_i),
                .done_o (t_done[gi])
            );
        end
    endgenerate

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_STANDBY;                       // sleep
        end else begin
            unique case (state_q)
                ST_STANDBY:   state_d = ST_SOFTSTART;   // wake
                ST_SOFTSTART: begin
                    unique case (evt)
                        EV_OTEMP: state_d = ST_COOLDOWN;
                        EV_SHORT: state_d = ST_RETRY;
                        EV_ILIM:  state_d = ST_LIMIT;
                        default:  if (ss_done_i) state_d = ST_RUN;
                    endcase
                end
                ST_RUN: begin
                    unique case (evt)
                        EV_OTEMP: state_d = ST_COOLDOWN;
                        EV_SHORT: state_d = ST_RETRY;
                        EV_ILIM:  state_d = ST_LIMIT;
                        default:  state_d = ST_RUN;
                    endcase
                end
                ST_LIMIT: begin
                    unique case (evt)
                        EV_OTEMP: state_d = ST_COOLDOWN;
                        EV_SHORT: state_d = ST_RETRY;
                        EV_ILIM:  if (t_done[TI_LIM]) state_d = ST_RETRY;
                        default:  state_d = ST_RUN;     // recover
                    endcase
                end
                ST_COOLDOWN:  if (temp_ok_i) state_d = ST_RETRY;
                ST_RETRY:     if (t_done[TI_RET]) state_d = ST_SOFTSTART;
                default:      state_d = ST_STANDBY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        out_en_o    = 1'b0;
        ss_req_o    = 1'b0;
        cbc_limit_o = 1'b0;
        fault_o     = 1'b0;
        unique case (state_q)
            ST_STANDBY:   ;
            ST_SOFTSTART: begin out_en_o = 1'b1; ss_req_o = 1'b1; end
            ST_RUN:       out_en_o = 1'b1;
            ST_LIMIT:     begin out_en_o = 1'b1; cbc_limit_o = 1'b1; end
            ST_COOLDOWN:  fault_o = 1'b1;
            ST_RETRY:     fault_o = 1'b1;
            default:      ;
        endcase
    end

    p_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_STANDBY));

    p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_STANDBY) |=> ss_req_o);

    p_short_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && short_i && !otemp_i && out_en_o) |=> (fault_o && state_q == ST_RETRY));

    p_overheat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && otemp_i && out_en_o) |=> (state_q == ST_COOLDOWN));

    p_cool_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !temp_ok_i && state_q == ST_COOLDOWN) |=> (state_q == ST_COOLDOWN));

    p_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_LIMIT && !ilim_i && !short_i && !otemp_i) |=> (state_q == ST_RUN));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_RETRY && t_done[TI_RET]) |=> ss_req_o);

    p_one_role_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_req_o, cbc_limit_o, fault_o}));

endmodule

// File: tb/psu_retry_seq_test.sv
module psu_retry_seq_test;

    localparam int LIM = 3;
    localparam int RET = 4;

    localparam logic [6:0] I_EN  = 7'b1000000;
    localparam logic [6:0] I_IL  = 7'b0100000;
    localparam logic [6:0] I_SH  = 7'b0010000;
    localparam logic [6:0] I_OT  = 7'b0001000;
    localparam logic [6:0] I_TOK = 7'b0000100;
    localparam logic [6:0] I_SSD = 7'b0000010;
    localparam logic [6:0] I_TK  = 7'b0000001;

    localparam logic [3:0] O_OFF = 4'b0000;
    localparam logic [3:0] O_SS  = 4'b1100;
    localparam logic [3:0] O_RUN = 4'b1000;
    localparam logic [3:0] O_LIM = 4'b1010;
    localparam logic [3:0] O_FLT = 4'b0001;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 0, ilim_i = 0, short_i = 0, otemp_i = 0, temp_ok_i = 0, ss_done_i = 0, tick_i = 0;
    logic out_en_o, ss_req_o, cbc_limit_o, fault_o;
    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    psu_retry_seq #(.LIMIT_TICKS(LIM), .RETRY_TICKS(RET)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .ilim_i(ilim_i), .short_i(short_i),
        .otemp_i(otemp_i), .temp_ok_i(temp_ok_i), .ss_done_i(ss_done_i), .tick_i(tick_i),
        .out_en_o(out_en_o), .ss_req_o(ss_req_o), .cbc_limit_o(cbc_limit_o), .fault_o(fault_o)
    );

    function automatic logic [3:0] outs();
        return {out_en_o, ss_req_o, cbc_limit_o, fault_o};
    endfunction

    task automatic compare(input logic [3:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, outs(), exp);
        end
    endtask

    // Driver: apply at a falling edge, queue the word due after the next rising edge.
    task automatic drive(input logic [6:0] in, input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        {en_i, ilim_i, short_i, otemp_i, temp_ok_i, ss_done_i, tick_i} = in;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare(it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(O_OFF, "R1 in reset");
        rst_n = 1'b1;
        drive(7'b0, O_OFF, "R1 standby en low");
        drive(7'b0, O_OFF, "R1 standby holds");

        // wake and ramp
        drive(I_EN, O_SS, "R2 wake");
        drive(I_EN, O_SS, "R3 ramp holds");
        drive(I_EN | I_SSD, O_RUN, "R3 ramp done");

        // overload, recover before expiry
        drive(I_EN | I_IL, O_LIM, "R4 overload");
        drive(I_EN | I_IL | I_TK, O_LIM, "R5 grace tick1");
        drive(I_EN | I_IL | I_TK, O_LIM, "R5 grace tick2");
        drive(I_EN, O_RUN, "R5 recover");

        // overload again: full grace needed (fresh timer), then expiry
        drive(I_EN | I_IL, O_LIM, "R5 re-entry");
        drive(I_EN | I_IL | I_TK, O_LIM, "R5 fresh tick1");
        drive(I_EN | I_IL | I_TK, O_LIM, "R5 fresh tick2");
        drive(I_EN | I_IL | I_TK, O_LIM, "R6 last tick");
        drive(I_EN | I_IL, O_FLT, "R6 grace expired");

        // retry delay, overload/short ignored
        for (int i = 0; i < RET; i++) drive(I_EN | I_IL | I_SH | I_TK, O_FLT, "R7 retry counting");
        drive(I_EN, O_SS, "R7 restart");

        // short during ramp and during run
        drive(I_EN | I_SH, O_FLT, "R8 short in ramp");
        for (int i = 0; i < RET; i++) drive(I_EN | I_TK, O_FLT, "R8 retry after short");
        drive(I_EN | I_SSD, O_SS, "R8 restart");
        drive(I_EN | I_SSD, O_RUN, "R3 run");
        drive(I_EN | I_SH | I_IL, O_FLT, "R11 short over ilim");
        for (int i = 0; i < RET; i++) drive(I_EN | I_TK, O_FLT, "R8 retry");
        drive(I_EN, O_SS, "R7 restart2");

        // all flags at once in ramp: thermal wins, ticks ignored
        drive(I_EN | I_OT | I_SH | I_IL | I_SSD, O_FLT, "R11 otemp first");
        for (int i = 0; i < RET + 2; i++) drive(I_EN | I_TK, O_FLT, "R10 cooldown ignores ticks");
        drive(I_EN, O_FLT, "R10 still cooling");
        drive(I_EN | I_TOK, O_FLT, "R10 cooled");
        for (int i = 0; i < RET; i++) drive(I_EN | I_TK, O_FLT, "R10 fresh retry");
        drive(I_EN, O_SS, "R10 restart");

        // thermal during limit
        drive(I_EN | I_IL, O_LIM, "R4 overload in ramp");
        drive(I_EN | I_IL | I_OT, O_FLT, "R9 otemp in limit");
        drive(I_EN | I_TOK, O_FLT, "R9 cooled");

        // sleep from retry clears the timer
        drive(I_EN | I_TK, O_FLT, "R12 retry tick1");
        drive(I_EN | I_TK, O_FLT, "R12 retry tick2");
        drive(7'b0, O_OFF, "R12 sleep from retry");
        drive(I_EN, O_SS, "R2 wake after sleep");
        drive(I_EN | I_SSD, O_RUN, "R3 run");
        drive(I_EN | I_SH, O_FLT, "R8 short in run");
        for (int i = 0; i < RET - 1; i++) drive(I_EN | I_TK, O_FLT, "R12 retry restarted");
        drive(I_EN, O_FLT, "R12 timer was cleared");
        drive(I_EN | I_TK, O_FLT, "R12 last tick");
        drive(I_EN, O_SS, "R7 restart3");

        // sleep from limit
        drive(I_EN | I_IL, O_LIM, "R4 overload");
        drive(I_IL, O_OFF, "R12 sleep from limit");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule